// File: doc/BRIEF.md
# Edge-Triggered Set/Clear State Machine

The block holds one output bit that goes high when the set input rises and goes low when the clear input rises. Falling inputs leave it alone. It reacts to input transitions, not levels, yet it keeps no copy of the past input values. The only memory is a two-bit state: the output bit `flag` and an auxiliary bit `aux`. Their pair records enough history to tell which input moved.

Each clock edge performs one state transition. The next state is computed from the two inputs and the present state, and the state register takes that value. After an input change the machine may pass through one intermediate, unstable state before it settles. Only one state bit changes per step, so no step depends on which bit would win a race. A `stable` output reports whether the present state is a rest point for the present inputs.

The caller changes at most one input at a time. Before changing an input again, it waits until `stable` is high.

Top module: `edge_sr_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state is forced to flag=0, aux=0, taking effect after that edge.
- R2: When `set_i` rises while `clr_i` holds and the machine was stable, `flag_o` is 1 after the next clock edge and stays 1 until the input pair changes again.
- R3: When `clr_i` rises while `set_i` holds and the machine was stable, `flag_o` is 0 after the next clock edge and stays 0 until the input pair changes again.
- R4: When either input falls while the machine was stable, `flag_o` keeps its previous value through the settling steps.
- R5: Stable states follow the encoding aux = flag for inputs (set,clr)=(0,0); aux = 0 for (0,1); aux = 1 for (1,0); aux = NOT flag for (1,1). `stable_o` is 1 exactly when the computed next state equals the present state, and is 0 in any intermediate state.
- R6: Between consecutive clock edges outside reset, at most one of `flag_o` and `aux_o` changes.
- R7: With the inputs held, the machine reaches a stable state within two clock edges. Once `stable_o` is high, the state does not change at the next edge.
- R8: From the rest point (set,clr,flag,aux)=(0,1,0,0), raising set steps to state 10 and rests at (1,1,1,0). Lowering clr then steps to state 11 and rests at (1,0,1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state transition per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| set_i | input | 1 | Set request; its rising transition drives the flag high |
| clr_i | input | 1 | Clear request; its rising transition drives the flag low |
| flag_o | output | 1 | Output state bit |
| aux_o | output | 1 | Auxiliary state bit |
| stable_o | output | 1 | High when the present state is a rest point for the present inputs |

## Verification
The edge assertions assume the other input held still on the edge where one input moved. They also assume the machine was stable on the cycle before, so each assertion reads an input change as a single move from a rest point. The stimulus meets this in two ways. It flips exactly one input per step, chosen at random. It then holds the inputs for three clocks, which is longer than the two-step settling bound, before the next flip. Resets are applied only while both inputs are low, where the reset state is already at rest.

// File: rtl/edge_sr_pkg.sv
// Package edge_sr_pkg
// Shared state type and settling bound for the edge-triggered set/clear machine.
package edge_sr_pkg;

    // State pair: flag is the visible output, aux records history.
    typedef struct packed {
        logic flag;
        logic aux;
    } sr_state_t;

    localparam sr_state_t ST_RESET   = '{flag: 1'b0, aux: 1'b0};
    // Longest run of unstable steps with the inputs held.
    localparam int        SETTLE_MAX = 2;
    localparam int        SETTLE_W   = $clog2(SETTLE_MAX + 2);

endpackage

// File: rtl/edge_sr_next.sv
// Module edge_sr_next
// Purely combinational next-state function of the machine.
// Each input column is a rule chosen so that every unstable state moves
// by exactly one bit toward the column's rest point.
// Assumes: the caller changes at most one input between rest points.
module edge_sr_next
    import edge_sr_pkg::*;
(
    input  logic      set_i,
    input  logic      clr_i,
    input  sr_state_t cur,
    output sr_state_t nxt
);

    // Select the transition rule for the present input column.
    always_comb begin
        nxt = cur;
        unique case ({set_i, clr_i})
            2'b00: begin  // both low: aux follows flag
                nxt.flag = cur.flag;
                nxt.aux  = cur.flag;
            end
            2'b01: begin  // clear high: drop flag only from a set-history row
                nxt.flag = cur.flag & ~cur.aux;
                nxt.aux  = cur.flag &  cur.aux;
            end
            2'b10: begin  // set high: raise flag only from a cleared-history row
                nxt.flag = cur.flag | ~cur.aux;
                nxt.aux  = cur.flag |  cur.aux;
            end
            default: begin  // both high: flag is the inverse of aux
                nxt.flag = ~cur.aux;
                nxt.aux  =  cur.aux;
            end
        endcase
    end

endmodule

// File: rtl/edge_sr_state.sv
// Module edge_sr_state
// State register: loads the next state on each rising edge.
// Synchronous active-low reset to ST_RESET.
module edge_sr_state
    import edge_sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sr_state_t nxt,
    output sr_state_t cur
);

    // Advance one transition per clock, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_RESET;
        else        cur <= nxt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cur == ST_RESET)); // R1

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(cur ^ $past(cur)) <= 1)); // R6

endmodule

// File: rtl/edge_sr_stable.sv
// Module edge_sr_stable
// Rest-point detector: flags when the next state equals the present one.
// Also tracks runs of unstable cycles under fixed inputs for its assertion.
module edge_sr_stable
    import edge_sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_i,
    input  logic      clr_i,
    input  sr_state_t cur,
    input  sr_state_t nxt,
    output logic      stable_o
);

    logic [1:0]          ins_q;
    logic [SETTLE_W-1:0] run_q;
    logic [SETTLE_W-1:0] run_d;

    // Rest point when the transition rule leaves the state unchanged.
    assign stable_o = (nxt == cur);

    // Count consecutive unstable cycles, restarting when the inputs move.
    always_comb begin
        if (stable_o)                      run_d = '0;
        else if ({set_i, clr_i} != ins_q)  run_d = SETTLE_W'(1);
        else if (run_q != '1)              run_d = run_q + SETTLE_W'(1);
        else                               run_d = run_q;
    end

    // Hold the previous inputs and the unstable run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_q <= 2'b00;
            run_q <= '0;
        end else begin
            ins_q <= {set_i, clr_i};
            run_q <= run_d;
        end
    end

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= SETTLE_W'(SETTLE_MAX)); // R7

    AST_REST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stable_o |=> (cur == $past(cur))); // R5

endmodule

// File: rtl/edge_sr_fsm.sv
// Module edge_sr_fsm
// Top level of the edge-triggered set/clear machine. A rising set input
// drives flag_o high and a rising clear input drives it low, using only
// the two state bits as memory.
// Assumes: one input changes at a time, and only while stable_o is high.
module edge_sr_fsm
    import edge_sr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic aux_o,
    output logic stable_o
);

    sr_state_t cur;
    sr_state_t nxt;

    edge_sr_next u_next (
        .set_i (set_i),
        .clr_i (clr_i),
        .cur   (cur),
        .nxt   (nxt)
    );

    edge_sr_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    edge_sr_stable u_stable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_i),
        .clr_i    (clr_i),
        .cur      (cur),
        .nxt      (nxt),
        .stable_o (stable_o)
    );

    // Expose the state bits.
    assign flag_o = cur.flag;
    assign aux_o  = cur.aux;

    AST_SET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(set_i) && $stable(clr_i) && $past(stable_o)
        |=> flag_o); // R2

    AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(clr_i) && $stable(set_i) && $past(stable_o)
        |=> !flag_o); // R3

    AST_FALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stable_o) &&
        (($fell(set_i) && $stable(clr_i)) || ($fell(clr_i) && $stable(set_i)))
        |=> (flag_o == $past(flag_o))); // R4

endmodule

// File: tb/edge_sr_fsm_bench.sv
// Bench for edge_sr_fsm: directed trajectories plus seeded random single-input flips.
module edge_sr_fsm_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic set_r;
    logic clr_r;
    logic flag_o;
    logic aux_o;
    logic stable_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic z_exp  = 1'b0;
    logic [1:0] first_zq;
    logic       first_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_sr_fsm u_edge_sr_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_r),
        .clr_i    (clr_r),
        .flag_o   (flag_o),
        .aux_o    (aux_o),
        .stable_o (stable_o)
    );

    // Rest-point aux value from the encoding in R5.
    function automatic logic aux_rest(input logic s, input logic c, input logic z);
        if (s && c) return ~z;
        if (s)      return 1'b1;
        if (c)      return 1'b0;
        return z;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_r = 1'b0;
        clr_r = 1'b0;
        repeat (2) @(negedge clk);
        check({flag_o, aux_o} == 2'b00, "R1", "state in reset", {flag_o, aux_o}, 0);
        rst_n = 1'b1;
        z_exp = 1'b0;
        @(negedge clk);
        check(stable_o == 1'b1, "R1", "stable after reset", stable_o, 1);
    endtask

    // Apply new inputs at a negedge, follow three clocks, check every step.
    task automatic apply(input logic ns, input logic nc);
        logic [1:0] prev;
        logic [1:0] now;
        string      req;
        if (ns && !set_r)      begin z_exp = 1'b1; req = "R2"; end
        else if (nc && !clr_r) begin z_exp = 1'b0; req = "R3"; end
        else                   req = "R4";
        prev  = {flag_o, aux_o};
        set_r = ns;
        clr_r = nc;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            now = {flag_o, aux_o};
            if (i == 0) begin
                first_zq = now;
                first_st = stable_o;
            end
            check($countones(now ^ prev) <= 1, "R6", "bits changed per step",
                  $countones(now ^ prev), 1);
            check(flag_o == z_exp, req, "flag after input change", flag_o, z_exp);
            prev = now;
        end
        check(stable_o == 1'b1, "R7", "settled within two clocks", stable_o, 1);
        check(aux_o == aux_rest(ns, nc, z_exp), "R5", "aux at rest point",
              aux_o, aux_rest(ns, nc, z_exp));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        set_r = 1'b0;
        clr_r = 1'b0;
        @(negedge clk);
        do_reset();

        // R8 trajectory: rest at 0100, set rises, clear falls.
        apply(1'b0, 1'b1);
        check({flag_o, aux_o} == 2'b00, "R8", "rest at 0100", {flag_o, aux_o}, 0);
        apply(1'b1, 1'b1);
        check(first_zq == 2'b10, "R8", "first step after set rises", first_zq, 2);
        check({flag_o, aux_o} == 2'b10, "R8", "rest at 1110", {flag_o, aux_o}, 2);
        apply(1'b1, 1'b0);
        check(first_zq == 2'b11, "R8", "first step after clear falls", first_zq, 3);
        check({flag_o, aux_o} == 2'b11, "R8", "rest at 1011", {flag_o, aux_o}, 3);

        // Two-step settle with an intermediate unstable state.
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1);
        check(first_zq == 2'b01, "R7", "intermediate state", first_zq, 1);
        check(first_st == 1'b0, "R5", "stable low mid-settle", first_st, 0);

        // Set rises from cleared rest with clear low: two steps 00->10->11.
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        check(first_st == 1'b0, "R5", "stable low after set rises", first_st, 0);
        check({flag_o, aux_o} == 2'b11, "R2", "set from idle", {flag_o, aux_o}, 3);

        // Random single-input flips, with one mid-run reset.
        for (int k = 0; k < 400; k++) begin
            if (k == 200) do_reset();
            if ($urandom % 2 == 0) apply(~set_r, clr_r);
            else                   apply(set_r, ~clr_r);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule